// File: doc/BRIEF.md
# NAK Counter Reload Controller

This block decides when a USB host controller refills the NAK counters of queue heads while it walks its circular asynchronous schedule. After each start event it waits for the first fetch of the queue head marked as head of list. From that fetch it refills the counter of every queue head it visits. It stops when the head-of-list queue head comes round again. As a result, each pass that follows a start event refills every counter exactly once.

The traversal logic presents one queue-head fetch at a time as a single-cycle strobe. With the strobe it supplies the head-of-list flag, the 4-bit reload value and the current NAK count. The block answers in the same cycle with the count to write back and a write strobe. The traversal logic also reports NAK handshakes on the current queue head, and the block answers each with a decremented count. A skip flag tells the traversal logic that a queue head has run out of NAK retries.

Top module: `nak_reload_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `phase_o` is 0 (idle) and `cnt_we_o` is 0 when no strobe is present. The phase encoding is 0 = idle, 1 = seeking head, 2 = refilling.
- R2: In phase 0, a cycle with `start_evt_i` high moves `phase_o` to 1 in the next cycle. Without a start event, phase 0 is held.
- R3: In phase 1, a fetch with `qh_head_i` high moves `phase_o` to 2 in the next cycle. That same fetch is refilled when its reload value is non-zero.
- R4: In phase 2, a fetch with `qh_head_i` low and a non-zero reload value drives `cnt_o` to the reload value with `cnt_we_o` high in the same cycle.
- R5: In phase 2, a fetch with `qh_head_i` high moves `phase_o` to 0 in the next cycle and is not refilled.
- R6: In phases 0 and 1, no fetch is refilled, except the head fetch of R3.
- R7: A fetch whose reload value is zero is never refilled, in any phase.
- R8: With `nak_i` high, `qh_fetch_i` low and a non-zero reload value, `cnt_o` is the input count minus one, saturating at 0, and `cnt_we_o` is high. With a zero reload value, `cnt_we_o` stays low. When nothing is written, `cnt_o` equals `qh_cnt_i`.
- R9: `skip_o` is high exactly for a fetch with a non-zero reload value that is not refilled and whose input count is 0.
- R10: A start event in phase 1 or 2 has no effect on `phase_o`.
- R11: When `nak_i` and `qh_fetch_i` are high in the same cycle, the NAK is ignored and only the fetch rules apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_evt_i | input | 1 | Start-event pulse |
| qh_fetch_i | input | 1 | Queue-head fetch strobe |
| qh_head_i | input | 1 | Head-of-list flag of the fetched queue head |
| qh_rl_i | input | 4 | Reload value of the current queue head |
| qh_cnt_i | input | 4 | Current NAK count of the current queue head |
| nak_i | input | 1 | NAK handshake seen on the current queue head |
| cnt_o | output | 4 | Count to write back |
| cnt_we_o | output | 1 | Write-back strobe |
| skip_o | output | 1 | Queue head has no retries left; do not issue |
| phase_o | output | 2 | Reload phase (0 idle, 1 seeking head, 2 refilling) |

## Verification
The assertions assume that the reload value and the count belong to the queue head named by the strobe in that same cycle, and that a fetch and a NAK are single-cycle events. The stimulus drives one vector per cycle, with every field of that vector consistent for one queue head. Its ordering walks the phases in their legal sequence: start, head, body fetches, head again. Start events and NAKs are placed both inside and outside the phases where they take effect.

// File: rtl/nrc_pkg.sv
package nrc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SEEK    = 2'd1,
    PH_REFILL  = 2'd2
  } phase_e;

  function automatic logic [3:0] sat_dec4(input logic [3:0] v);
    return (v == 4'd0) ? 4'd0 : v - 4'd1;
  endfunction

  function automatic logic rl_live(input logic [3:0] rl);
    return rl != 4'd0;
  endfunction
endpackage

// File: rtl/nrc_fsm.sv
module nrc_fsm
  import nrc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_evt,
  input  logic       fetch,
  input  logic       head,
  input  logic       rl_nz,
  output phase_e     phase,
  output logic       refill_now
);
  phase_e nxt;
  logic   head_seen;
  assign head_seen = fetch && head;

  always_comb begin
    nxt = phase;
    unique case (phase)
      PH_IDLE:   if (start_evt) nxt = PH_SEEK;
      PH_SEEK:   if (head_seen) nxt = PH_REFILL;
      PH_REFILL: if (head_seen) nxt = PH_IDLE;
      default:   nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= nxt;
  end

  // Refill: body fetches while refilling, plus the opening head fetch.
  always_comb begin
    refill_now = 1'b0;
    if (fetch && rl_nz) begin
      if (phase == PH_REFILL && !head) refill_now = 1'b1;
      if (phase == PH_SEEK && head)    refill_now = 1'b1;
    end
  end

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && !start_evt) |=> phase == PH_IDLE);
  a_r2_idle_leave: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && start_evt) |=> phase == PH_SEEK);
  a_r3_enter_refill: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SEEK && fetch && head) |=> phase == PH_REFILL);
  a_r5_close_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_REFILL && fetch && head) |=> phase == PH_IDLE);
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && !(fetch && head)) |=> $stable(phase));
endmodule

// File: rtl/nrc_cnt_path.sv
module nrc_cnt_path
  import nrc_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch,
  input  logic             nak,
  input  logic [CNT_W-1:0] rl,
  input  logic [CNT_W-1:0] cnt,
  input  logic             refill_now,
  output logic [CNT_W-1:0] cnt_out,
  output logic             we,
  output logic             skip
);
  logic nak_dec;
  assign nak_dec = nak && !fetch && rl_live(rl);

  always_comb begin
    cnt_out = cnt;
    we      = 1'b0;
    if (refill_now) begin
      cnt_out = rl;
      we      = 1'b1;
    end else if (nak_dec) begin
      cnt_out = sat_dec4(cnt);
      we      = 1'b1;
    end
  end

  assign skip = fetch && rl_live(rl) && !refill_now && (cnt == '0);

  a_r7_zero_rl_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (rl == '0) |-> !we);
  a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (nak && !fetch && cnt == '0) |-> cnt_out == '0);
  a_r11_nak_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch && !refill_now) |-> !we);
  a_r9_skip_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    skip |-> !we);
endmodule

// File: rtl/nak_reload_ctrl.sv
module nak_reload_ctrl
  import nrc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_evt_i,
  input  logic       qh_fetch_i,
  input  logic       qh_head_i,
  input  logic [3:0] qh_rl_i,
  input  logic [3:0] qh_cnt_i,
  input  logic       nak_i,
  output logic [3:0] cnt_o,
  output logic       cnt_we_o,
  output logic       skip_o,
  output logic [1:0] phase_o
);
  phase_e phase;
  logic   refill_now;

  nrc_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt_i), .fetch(qh_fetch_i),
    .head(qh_head_i), .rl_nz(rl_live(qh_rl_i)), .phase(phase),
    .refill_now(refill_now)
  );

  nrc_cnt_path #(.CNT_W(4)) u_cnt (
    .clk(clk), .rst_n(rst_n), .fetch(qh_fetch_i), .nak(nak_i),
    .rl(qh_rl_i), .cnt(qh_cnt_i), .refill_now(refill_now),
    .cnt_out(cnt_o), .we(cnt_we_o), .skip(skip_o)
  );

  assign phase_o = phase;

  a_r6_no_refill_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && qh_fetch_i) |-> !cnt_we_o);
  a_r5_head_not_refilled: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_REFILL && qh_fetch_i && qh_head_i) |-> !cnt_we_o);
endmodule

// File: tb/nak_reload_ctrl_tb.sv
module nak_reload_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_evt_i, qh_fetch_i, qh_head_i, nak_i;
  logic [3:0] qh_rl_i, qh_cnt_i, cnt_o;
  logic       cnt_we_o, skip_o;
  logic [1:0] phase_o;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  nak_reload_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .start_evt_i(start_evt_i), .qh_fetch_i(qh_fetch_i),
    .qh_head_i(qh_head_i), .qh_rl_i(qh_rl_i), .qh_cnt_i(qh_cnt_i), .nak_i(nak_i),
    .cnt_o(cnt_o), .cnt_we_o(cnt_we_o), .skip_o(skip_o), .phase_o(phase_o)
  );

  typedef struct packed {
    logic       st; logic fe; logic hd; logic [3:0] rl; logic [3:0] cn; logic nk;
    logic [1:0] ph; logic we; logic [3:0] co; logic sk;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b1,1'b1,4'd5,4'd2,1'b0, 2'd0,1'b0,4'd2,1'b0}, // R6 idle head fetch
    '{1'b0,1'b0,1'b0,4'd5,4'd2,1'b1, 2'd0,1'b1,4'd1,1'b0}, // R8 nak dec
    '{1'b1,1'b0,1'b0,4'd0,4'd0,1'b0, 2'd0,1'b0,4'd0,1'b0}, // R2 start
    '{1'b0,1'b1,1'b0,4'd3,4'd1,1'b0, 2'd1,1'b0,4'd1,1'b0}, // R6 seek body
    '{1'b0,1'b1,1'b1,4'd7,4'd0,1'b0, 2'd1,1'b1,4'd7,1'b0}, // R3 head refilled
    '{1'b1,1'b0,1'b0,4'd0,4'd0,1'b0, 2'd2,1'b0,4'd0,1'b0}, // R10 start in refill
    '{1'b0,1'b1,1'b0,4'd9,4'd2,1'b0, 2'd2,1'b1,4'd9,1'b0}, // R4 body refill
    '{1'b0,1'b1,1'b0,4'd0,4'd0,1'b0, 2'd2,1'b0,4'd0,1'b0}, // R7 zero rl
    '{1'b0,1'b1,1'b0,4'd4,4'd3,1'b1, 2'd2,1'b1,4'd4,1'b0}, // R11 nak masked
    '{1'b0,1'b0,1'b0,4'd4,4'd0,1'b1, 2'd2,1'b1,4'd0,1'b0}, // R8 saturate
    '{1'b0,1'b1,1'b1,4'd6,4'd0,1'b0, 2'd2,1'b0,4'd0,1'b1}, // R5 head closes, R9 skip
    '{1'b0,1'b1,1'b0,4'd6,4'd3,1'b0, 2'd0,1'b0,4'd3,1'b0}, // R5 back idle, R6
    '{1'b0,1'b1,1'b0,4'd6,4'd0,1'b0, 2'd0,1'b0,4'd0,1'b1}, // R9 skip idle
    '{1'b1,1'b0,1'b0,4'd0,4'd0,1'b0, 2'd0,1'b0,4'd0,1'b0}, // R2 start
    '{1'b0,1'b0,1'b0,4'd0,4'd0,1'b0, 2'd1,1'b0,4'd0,1'b0}, // R2 seek
    '{1'b1,1'b0,1'b0,4'd0,4'd0,1'b0, 2'd1,1'b0,4'd0,1'b0}, // R10 start in seek
    '{1'b0,1'b0,1'b0,4'd2,4'd5,1'b1, 2'd1,1'b1,4'd4,1'b0}  // R10 still seek, R8
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    start_evt_i = v.st; qh_fetch_i = v.fe; qh_head_i = v.hd;
    qh_rl_i = v.rl; qh_cnt_i = v.cn; nak_i = v.nk;
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive('0);
    repeat (3) @(negedge clk);
    #3;
    chk("R1 phase", phase_o, 0);
    chk("R1 we", cnt_we_o, 0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      #3;
      chk($sformatf("vec%0d phase", i), phase_o, VEC[i].ph);
      chk($sformatf("vec%0d we", i), cnt_we_o, VEC[i].we);
      chk($sformatf("vec%0d cnt", i), cnt_o, VEC[i].co);
      chk($sformatf("vec%0d skip", i), skip_o, VEC[i].sk);
    end
    // R8: nak with zero reload value writes nothing
    @(negedge clk);
    drive('0); nak_i = 1'b1; qh_cnt_i = 4'd3;
    #3;
    chk("R8 zero rl nak we", cnt_we_o, 0);
    chk("R8 zero rl nak cnt", cnt_o, 3);
    // R1: reset mid-pass returns to idle
    @(negedge clk);
    drive('0); rst_n = 1'b0;
    @(negedge clk);
    #3;
    chk("R1 reset mid-pass", phase_o, 0);
    rst_n = 1'b1;
    // R2: idle holds without start
    drive('0);
    repeat (2) @(negedge clk);
    #3;
    chk("R2 idle hold", phase_o, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule